// File: doc/BRIEF.md
# SWD register transaction engine

This block is a Serial Wire Debug host that performs one 32-bit register access at a time on a debug port (DP) or an access port (AP). A requester hands it an operation over a valid/ready request channel. The engine then serialises the frame onto SWCLK and a bidirectional SWDIO (split into data-out, output-enable and data-in pins). When the frame is over, it returns read data and a status code over a valid/ready response channel.

The engine handles the protocol work itself.
- A WAIT acknowledge makes it write the abort register to clear the sticky flags, and it then repeats the original access.
- A FAULT, an unknown acknowledge or a read parity mismatch is latched as an error. While an error is latched, later accesses are turned away without touching the wire.
- A flush operation clocks eight idle bits with the line released, reports the latched error and clears it.
- After a successful AP access, a programmable number of released clocks follows.
- Two line sequences are available: a line reset and a JTAG-to-SWD switch.

Each SWD bit lasts `2*HALF_CYC` core clocks. Back-pressure rules:
- A request is taken only in a cycle where `req_valid` and `req_ready` are both high. `req_ready` is high only while the engine is idle.
- A response stays on the port, unchanged, from the first cycle `rsp_valid` is high until the cycle `rsp_ready` is seen. No new request is accepted before then.

Top module: `swd_xact_engine`

## Requirements
- R1: Every access starts with an 8-bit header driven LSB first. Its bits are: bit0 = 1, bit1 = AP select, bit2 = read, bit3 = `req_addr[0]`, bit4 = `req_addr[1]`, bit5 = XOR of bits 1 to 4, bit6 = 0, bit7 = 1.
- R2: After a read header the engine releases SWDIO for 38 bits: one turnaround, 3 acknowledge bits, 32 data bits LSB first, one parity bit and one turnaround. It drives the line again afterwards.
- R3: After a write header the engine releases SWDIO for 5 bits (turnaround, 3 acknowledge bits, turnaround). It then drives the 32 write-data bits LSB first, followed by their parity (XOR of all 32 bits).
- R4: Acknowledge bits are received LSB first and decode as OK = 3'b001, WAIT = 3'b010 and FAULT = 3'b100. An OK read returns the received word on `rsp_rdata` with status 4'h0.
- R5: If an OK read carries a parity bit different from the XOR of its data, status 4'h8 is latched and reported.
- R6: On WAIT the engine sends a DP write to address 0 with data 0x0000001E (the four sticky-clear bits 1 to 4). It treats that frame's own acknowledge the same way, and after an OK it repeats the original access.
- R7: FAULT or any acknowledge other than OK and WAIT latches status {1'b0, ack} without retry. A response never carries status 4'h1 or 4'h2.
- R8: While a nonzero status is latched, a read or write produces no SWCLK pulse and is answered with the latched status.
- R9: A flush (op 2) clocks 8 bits with SWDIO released, reports the latched status and then clears it to 4'h0.
- R10: An OK access with `req_ap` = 1 is followed by `ap_delay` released bits, where `ap_delay` is sampled at acceptance. DP accesses and a delay of 0 add none.
- R11: Line reset (op 3) drives SEQ_ONES bits of 1. JTAG-to-SWD (op 4) drives SEQ_ONES ones, then 16'hE79E LSB first, then SEQ_ONES ones. Both report the latched status unchanged.
- R12: SWDIO output and enable change only while SWCLK is low. Input is sampled at the core edge that raises SWCLK. In idle, SWCLK is low and SWDIO is driven low.
- R13: Operation codes are 0 read, 1 write, 2 flush, 3 line reset and 4 JTAG-to-SWD; other codes respond at once. `req_ready` is high only in idle and never together with `rsp_valid`, and each response is held until accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Engine idle, request accepted this cycle if valid |
| req_op | input | 3 | Operation code (see R13) |
| req_ap | input | 1 | 1 = access port, 0 = debug port |
| req_addr | input | 2 | Register address bits 3:2 |
| req_wdata | input | 32 | Write data |
| ap_delay | input | DELAY_W | Released clocks after an OK AP access |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Response consumed |
| rsp_rdata | output | 32 | Last successfully read word |
| rsp_status | output | 4 | 0 OK, {0,ack} for a bad acknowledge, 8 parity error |
| swclk | output | 1 | Serial wire clock |
| swdio_out | output | 1 | SWDIO value when driven |
| swdio_oe | output | 1 | 1 = host drives SWDIO |
| swdio_in | input | 1 | SWDIO as seen at the pin |

## Verification
The checker assumes that the requester holds the request fields steady while `req_valid` waits. It also assumes that `rsp_ready` is the only thing that ends a response, and that the target presents each read bit before the SWCLK rise in which it is sampled. The bench keeps within these limits: it presents one request at a time and leaves `rsp_ready` low for several cycles before accepting. Its target model places every released bit on `swdio_in` as soon as the previous rise has been consumed. WAIT sequences are kept finite, so a retry loop always ends in an OK acknowledge.

// File: rtl/swd_xact_pkg.sv
package swd_xact_pkg;

  localparam int WORD_W     = 32;
  localparam int SHIFT_W    = WORD_W + 1;
  localparam int CAP_W      = 38;
  localparam int HDR_BITS   = 8;
  localparam int RD_TAIL    = 38;
  localparam int WR_GAP     = 5;
  localparam int FLUSH_BITS = 8;
  localparam int PAT_BITS   = 16;

  typedef enum logic [2:0] {
    OP_READ   = 3'd0,
    OP_WRITE  = 3'd1,
    OP_FLUSH  = 3'd2,
    OP_LRESET = 3'd3,
    OP_TO_SWD = 3'd4
  } swd_op_e;

  localparam logic [2:0]        ACK_OK      = 3'b001;
  localparam logic [2:0]        ACK_WAIT    = 3'b010;
  localparam logic [3:0]        STS_OK      = 4'h0;
  localparam logic [3:0]        STS_PARITY  = 4'h8;
  localparam logic [WORD_W-1:0] STICKY_WIPE = 32'h0000_001E;
  localparam logic [15:0]       TO_SWD_PAT  = 16'hE79E;

  function automatic logic [7:0] hdr_byte(input logic ap, input logic rd,
                                          input logic [1:0] a);
    return {1'b1, 1'b0, ap ^ rd ^ a[0] ^ a[1], a[1], a[0], rd, ap, 1'b1};
  endfunction

  function automatic logic word_par(input logic [WORD_W-1:0] w);
    return ^w;
  endfunction

endpackage

// File: rtl/swd_clk_phase.sv
module swd_clk_phase #(
  parameter int HALF_CYC = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic swclk,
  output logic rise,
  output logic fall
);
  localparam int CW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_CYC - 1);

  logic [CW-1:0] cnt;
  logic          ph;
  logic          step;

  assign step  = run && (cnt == LAST);
  assign swclk = ph;
  assign rise  = step && !ph;
  assign fall  = step && ph;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph  <= 1'b0;
      cnt <= '0;
    end else if (!run) begin
      ph  <= 1'b0;
      cnt <= '0;
    end else if (step) begin
      ph  <= ~ph;
      cnt <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/swd_seg_shifter.sv
module swd_seg_shifter #(
  parameter int SH_W  = 33,
  parameter int CNT_W = 8,
  parameter int CAP_W = 38
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] ld_len,
  input  logic             ld_drive,
  input  logic             ld_fill,
  input  logic [SH_W-1:0]  ld_data,
  input  logic             rise,
  input  logic             fall,
  input  logic             din,
  output logic             active,
  output logic             dout,
  output logic             doe,
  output logic             seg_done,
  output logic [CAP_W-1:0] cap
);
  logic [SH_W-1:0]  sh;
  logic [CNT_W-1:0] left;
  logic             drive;
  logic             fill;

  assign seg_done = active && fall && (left == CNT_W'(1));
  assign dout     = active ? sh[0] : 1'b0;
  assign doe      = active ? drive : 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh     <= '0;
      left   <= '0;
      drive  <= 1'b1;
      fill   <= 1'b0;
      active <= 1'b0;
    end else if (load) begin
      sh     <= ld_data;
      left   <= ld_len;
      drive  <= ld_drive;
      fill   <= ld_fill;
      active <= 1'b1;
    end else if (active && fall) begin
      sh   <= {fill, sh[SH_W-1:1]};
      left <= left - 1'b1;
      if (left == CNT_W'(1)) active <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cap <= '0;
    else if (active && !drive && rise) cap <= {din, cap[CAP_W-1:1]};
  end
endmodule

// File: rtl/swd_xact_ctrl.sv
module swd_xact_ctrl
  import swd_xact_pkg::*;
#(
  parameter int DELAY_W  = 8,
  parameter int SEQ_ONES = 50,
  parameter int CNT_W    = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [2:0]         req_op,
  input  logic               req_ap,
  input  logic [1:0]         req_addr,
  input  logic [WORD_W-1:0]  req_wdata,
  input  logic [DELAY_W-1:0] ap_delay,
  output logic               rsp_valid,
  input  logic               rsp_ready,
  output logic [WORD_W-1:0]  rsp_rdata,
  output logic [3:0]         rsp_status,
  input  logic               seg_done,
  input  logic [CAP_W-1:0]   cap,
  output logic               ld,
  output logic [CNT_W-1:0]   ld_len,
  output logic               ld_drive,
  output logic               ld_fill,
  output logic [SHIFT_W-1:0] ld_data
);
  typedef enum logic [3:0] {
    S_IDLE, S_HDR, S_RDF, S_WGAP, S_WDAT, S_POST,
    S_FLUSH, S_ONES1, S_PAT, S_ONES2, S_RSP
  } st_e;

  // positions inside the capture window after the last released segment
  localparam int RD_ACK_LO = 1;
  localparam int RD_DAT_LO = 4;
  localparam int RD_PAR    = 36;
  localparam int WR_ACK_LO = 34;

  st_e                st_q, st_d;
  swd_op_e            op_q;
  logic               ap_q;
  logic [1:0]         addr_q;
  logic [WORD_W-1:0]  wdata_q, rdata_q, rdata_d;
  logic [DELAY_W-1:0] delay_q;
  logic [3:0]         sts_q, sts_d;
  logic               abort_q, abort_d;
  logic               take;
  logic [2:0]         ack;
  logic [WORD_W-1:0]  rd_word;
  logic [WORD_W-1:0]  out_word;
  logic               cur_rd;

  assign req_ready  = (st_q == S_IDLE);
  assign rsp_valid  = (st_q == S_RSP);
  assign rsp_rdata  = rdata_q;
  assign rsp_status = sts_q;
  assign take       = req_valid && req_ready;
  assign ack        = (st_q == S_RDF) ? cap[RD_ACK_LO +: 3] : cap[WR_ACK_LO +: 3];
  assign rd_word    = cap[RD_DAT_LO +: WORD_W];
  assign out_word   = abort_q ? STICKY_WIPE : wdata_q;
  assign cur_rd     = !abort_q && (op_q == OP_READ);

  always_comb begin
    st_d     = st_q;
    sts_d    = sts_q;
    rdata_d  = rdata_q;
    abort_d  = abort_q;
    ld       = 1'b0;
    ld_len   = '0;
    ld_drive = 1'b1;
    ld_fill  = 1'b0;
    ld_data  = '0;
    unique case (st_q)
      S_IDLE: if (req_valid) begin
        unique case (swd_op_e'(req_op))
          OP_READ, OP_WRITE: begin
            if (sts_q != STS_OK) st_d = S_RSP;
            else begin
              ld      = 1'b1;
              ld_len  = CNT_W'(HDR_BITS);
              ld_data = SHIFT_W'(hdr_byte(req_ap, req_op == OP_READ, req_addr));
              st_d    = S_HDR;
            end
          end
          OP_FLUSH: begin
            ld       = 1'b1;
            ld_len   = CNT_W'(FLUSH_BITS);
            ld_drive = 1'b0;
            st_d     = S_FLUSH;
          end
          OP_LRESET, OP_TO_SWD: begin
            ld      = 1'b1;
            ld_len  = CNT_W'(SEQ_ONES);
            ld_fill = 1'b1;
            ld_data = '1;
            st_d    = (req_op == OP_LRESET) ? S_ONES2 : S_ONES1;
          end
          default: st_d = S_RSP;
        endcase
      end
      S_HDR: if (seg_done) begin
        ld       = 1'b1;
        ld_drive = 1'b0;
        ld_len   = cur_rd ? CNT_W'(RD_TAIL) : CNT_W'(WR_GAP);
        st_d     = cur_rd ? S_RDF : S_WGAP;
      end
      S_WGAP: if (seg_done) begin
        ld      = 1'b1;
        ld_len  = CNT_W'(SHIFT_W);
        ld_data = {word_par(out_word), out_word};
        st_d    = S_WDAT;
      end
      S_RDF, S_WDAT: if (seg_done) begin
        if (ack == ACK_OK) begin
          if (st_q == S_RDF && cap[RD_PAR] != word_par(rd_word)) begin
            sts_d = STS_PARITY;
            st_d  = S_RSP;
          end else if (abort_q) begin
            abort_d = 1'b0;
            ld      = 1'b1;
            ld_len  = CNT_W'(HDR_BITS);
            ld_data = SHIFT_W'(hdr_byte(ap_q, op_q == OP_READ, addr_q));
            st_d    = S_HDR;
          end else begin
            if (st_q == S_RDF) rdata_d = rd_word;
            if (ap_q && delay_q != '0) begin
              ld       = 1'b1;
              ld_drive = 1'b0;
              ld_len   = CNT_W'(delay_q);
              st_d     = S_POST;
            end else begin
              st_d = S_RSP;
            end
          end
        end else if (ack == ACK_WAIT) begin
          abort_d = 1'b1;
          ld      = 1'b1;
          ld_len  = CNT_W'(HDR_BITS);
          ld_data = SHIFT_W'(hdr_byte(1'b0, 1'b0, 2'b00));
          st_d    = S_HDR;
        end else begin
          sts_d   = {1'b0, ack};
          abort_d = 1'b0;
          st_d    = S_RSP;
        end
      end
      S_ONES1: if (seg_done) begin
        ld      = 1'b1;
        ld_len  = CNT_W'(PAT_BITS);
        ld_data = SHIFT_W'(TO_SWD_PAT);
        st_d    = S_PAT;
      end
      S_PAT: if (seg_done) begin
        ld      = 1'b1;
        ld_len  = CNT_W'(SEQ_ONES);
        ld_fill = 1'b1;
        ld_data = '1;
        st_d    = S_ONES2;
      end
      S_POST, S_FLUSH, S_ONES2: if (seg_done) st_d = S_RSP;
      S_RSP: if (rsp_ready) begin
        st_d = S_IDLE;
        if (op_q == OP_FLUSH) sts_d = STS_OK;
      end
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= S_IDLE;
      sts_q   <= STS_OK;
      rdata_q <= '0;
      abort_q <= 1'b0;
      op_q    <= OP_READ;
      ap_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      delay_q <= '0;
    end else begin
      st_q    <= st_d;
      sts_q   <= sts_d;
      rdata_q <= rdata_d;
      abort_q <= abort_d;
      if (take) begin
        op_q    <= swd_op_e'(req_op);
        ap_q    <= req_ap;
        addr_q  <= req_addr;
        wdata_q <= req_wdata;
        delay_q <= ap_delay;
      end
    end
  end
endmodule

// File: rtl/swd_xact_engine.sv
module swd_xact_engine
  import swd_xact_pkg::*;
#(
  parameter int HALF_CYC = 1,
  parameter int DELAY_W  = 8,
  parameter int SEQ_ONES = 50
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [2:0]         req_op,
  input  logic               req_ap,
  input  logic [1:0]         req_addr,
  input  logic [31:0]        req_wdata,
  input  logic [DELAY_W-1:0] ap_delay,
  output logic               rsp_valid,
  input  logic               rsp_ready,
  output logic [31:0]        rsp_rdata,
  output logic [3:0]         rsp_status,
  output logic               swclk,
  output logic               swdio_out,
  output logic               swdio_oe,
  input  logic               swdio_in
);
  localparam int DLY_MAX = (1 << DELAY_W) - 1;
  localparam int LEN_A   = (DLY_MAX > SEQ_ONES) ? DLY_MAX : SEQ_ONES;
  localparam int LEN_MAX = (LEN_A > RD_TAIL) ? LEN_A : RD_TAIL;
  localparam int CNT_W   = $clog2(LEN_MAX + 1);

  logic               run, rise, fall;
  logic               seg_done, ld, ld_drive, ld_fill;
  logic [CNT_W-1:0]   ld_len;
  logic [SHIFT_W-1:0] ld_data;
  logic [CAP_W-1:0]   cap;

  swd_clk_phase #(.HALF_CYC(HALF_CYC)) u_phase (
    .clk(clk), .rst_n(rst_n), .run(run),
    .swclk(swclk), .rise(rise), .fall(fall)
  );

  swd_seg_shifter #(.SH_W(SHIFT_W), .CNT_W(CNT_W), .CAP_W(CAP_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .load(ld), .ld_len(ld_len),
    .ld_drive(ld_drive), .ld_fill(ld_fill), .ld_data(ld_data),
    .rise(rise), .fall(fall), .din(swdio_in),
    .active(run), .dout(swdio_out), .doe(swdio_oe),
    .seg_done(seg_done), .cap(cap)
  );

  swd_xact_ctrl #(.DELAY_W(DELAY_W), .SEQ_ONES(SEQ_ONES), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
    .req_ap(req_ap), .req_addr(req_addr), .req_wdata(req_wdata),
    .ap_delay(ap_delay),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_rdata(rsp_rdata), .rsp_status(rsp_status),
    .seg_done(seg_done), .cap(cap),
    .ld(ld), .ld_len(ld_len), .ld_drive(ld_drive),
    .ld_fill(ld_fill), .ld_data(ld_data)
  );
endmodule

// File: rtl/swd_xact_checker.sv
module swd_xact_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid,
  input logic       req_ready,
  input logic [2:0] req_op,
  input logic       rsp_valid,
  input logic       rsp_ready,
  input logic [31:0] rsp_rdata,
  input logic [3:0] rsp_status,
  input logic       swclk,
  input logic       swdio_out,
  input logic       swdio_oe
);
  logic [2:0] op_m;
  logic [3:0] err_m;
  logic       skip_m;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_m   <= 3'd0;
      err_m  <= 4'h0;
      skip_m <= 1'b0;
    end else begin
      if (req_valid && req_ready) begin
        op_m   <= req_op;
        skip_m <= (req_op == 3'd0 || req_op == 3'd1) && (err_m != 4'h0);
      end
      if (rsp_valid && rsp_ready) begin
        err_m  <= (op_m == 3'd2) ? 4'h0 : rsp_status;
        skip_m <= 1'b0;
      end
    end
  end

  AST_PIN_MOVES_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (swdio_out != $past(swdio_out) || swdio_oe != $past(swdio_oe)) |-> !swclk); // R12
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!swclk && swdio_oe && !swdio_out)); // R12
  AST_RSP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_status) && $stable(rsp_rdata))); // R13
  AST_ONE_SIDE: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_ready && rsp_valid)); // R13
  AST_SKIP_NO_CLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    skip_m |-> !swclk); // R8
  AST_SKIP_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    (skip_m && rsp_valid) |-> (rsp_status == err_m)); // R8
  AST_NO_PASSING_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_status != 4'h1 && rsp_status != 4'h2)); // R7
endmodule

bind swd_xact_engine swd_xact_checker u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_op(req_op), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
  .rsp_rdata(rsp_rdata), .rsp_status(rsp_status), .swclk(swclk),
  .swdio_out(swdio_out), .swdio_oe(swdio_oe)
);

// File: tb/tb_swd_xact_engine.sv
module tb_swd_xact_engine;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_ready;
  logic [2:0]  req_op = 3'd0;
  logic        req_ap = 1'b0;
  logic [1:0]  req_addr = 2'd0;
  logic [31:0] req_wdata = 32'd0;
  logic [7:0]  ap_delay = 8'd0;
  logic        rsp_valid, rsp_ready = 1'b0;
  logic [31:0] rsp_rdata;
  logic [3:0]  rsp_status;
  logic        swclk, swdio_out, swdio_oe;
  logic        tgt_bit = 1'b0;

  int    checks = 0, fails = 0;
  int    q_bits[$];
  string q_tag[$];
  logic  prev_clk = 1'b0;
  bit    finished = 1'b0;

  always #5 clk = ~clk;

  swd_xact_engine dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_ap(req_ap), .req_addr(req_addr),
    .req_wdata(req_wdata), .ap_delay(ap_delay), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata), .rsp_status(rsp_status),
    .swclk(swclk), .swdio_out(swdio_out), .swdio_oe(swdio_oe),
    .swdio_in(tgt_bit)
  );

  function automatic void refresh();
    tgt_bit = (q_bits.size() > 0 && q_bits[0][1] == 1'b0) ? q_bits[0][0] : 1'b0;
  endfunction

  task automatic chk(input string tag, input string what,
                     input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // model of the wire: every SWCLK rise consumes one expected bit
  always @(negedge clk) begin
    if (rst_n && swclk && !prev_clk) begin
      checks++;
      if (q_bits.size() == 0) begin
        fails++;
        $display("FAIL R12 unexpected SWCLK pulse: actual pulse expected none");
      end else begin
        int    e;
        string t;
        e = q_bits.pop_front();
        t = q_tag.pop_front();
        if (e[1] && (!swdio_oe || swdio_out != e[0])) begin
          fails++;
          $display("FAIL %s driven bit: actual oe=%0b val=%0b expected oe=1 val=%0b",
                   t, swdio_oe, swdio_out, e[0]);
        end else if (!e[1] && swdio_oe) begin
          fails++;
          $display("FAIL %s released bit: actual oe=1 expected oe=0", t);
        end
        refresh();
      end
    end
    prev_clk <= swclk;
  end

  task automatic push_bits(input logic [63:0] v, input int n, input bit drv,
                           input string tag);
    for (int i = 0; i < n; i++) begin
      q_bits.push_back({30'd0, drv, v[i]});
      q_tag.push_back(tag);
    end
    refresh();
  endtask

  function automatic logic [7:0] hdr(input logic ap, input logic rd, input logic [1:0] a);
    logic [7:0] b;
    b[0] = 1'b1; b[1] = ap; b[2] = rd; b[3] = a[0]; b[4] = a[1];
    b[5] = ap ^ rd ^ a[0] ^ a[1]; b[6] = 1'b0; b[7] = 1'b1;
    return b;
  endfunction

  task automatic exp_read(input logic ap, input logic [1:0] a, input logic [2:0] ackv,
                          input logic [31:0] d, input logic flip);
    push_bits(64'(hdr(ap, 1'b1, a)), 8, 1'b1, "R1");
    push_bits(64'd0, 1, 1'b0, "R2");
    push_bits(64'(ackv), 3, 1'b0, "R4");
    push_bits(64'(d), 32, 1'b0, "R2");
    push_bits(64'((^d) ^ flip), 1, 1'b0, "R5");
    push_bits(64'd0, 1, 1'b0, "R2");
  endtask

  task automatic exp_write(input logic ap, input logic [1:0] a, input logic [2:0] ackv,
                           input logic [31:0] d, input string tag);
    push_bits(64'(hdr(ap, 1'b0, a)), 8, 1'b1, "R1");
    push_bits(64'd0, 1, 1'b0, tag);
    push_bits(64'(ackv), 3, 1'b0, "R4");
    push_bits(64'd0, 1, 1'b0, tag);
    push_bits(64'(d), 32, 1'b1, tag);
    push_bits(64'(^d), 1, 1'b1, tag);
  endtask

  task automatic exp_abort(input logic [2:0] ackv);
    exp_write(1'b0, 2'd0, ackv, 32'h0000_001E, "R6");
  endtask

  task automatic run_op(input logic [2:0] op, input logic ap, input logic [1:0] a,
                        input logic [31:0] wd, input logic [7:0] dly,
                        input logic [3:0] exp_sts, input bit chk_rd,
                        input logic [31:0] exp_rd, input string tag);
    @(negedge clk);
    req_op = op; req_ap = ap; req_addr = a; req_wdata = wd; ap_delay = dly;
    req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    while (!rsp_valid) @(negedge clk);
    repeat (3) @(negedge clk);
    chk(tag, "status", rsp_status, exp_sts);
    if (chk_rd) chk(tag, "read data", rsp_rdata, exp_rd);
    chk(tag, "bits left unclocked", q_bits.size(), 0);
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R12 R13: idle state after reset
    chk("R12", "swclk", swclk, 0);
    chk("R12", "oe", swdio_oe, 1);
    chk("R12", "out", swdio_out, 0);
    chk("R13", "req_ready", req_ready, 1);
    chk("R13", "rsp_valid", rsp_valid, 0);

    exp_read(1'b0, 2'd1, 3'b001, 32'h1234_5678, 1'b0);
    run_op(3'd0, 1'b0, 2'd1, 32'd0, 8'd0, 4'h0, 1, 32'h1234_5678, "R2");
    exp_read(1'b0, 2'd2, 3'b001, 32'h0000_0000, 1'b0);
    run_op(3'd0, 1'b0, 2'd2, 32'd0, 8'd9, 4'h0, 1, 32'h0, "R4");
    exp_write(1'b0, 2'd2, 3'b001, 32'hA5A5_F00F, "R3");
    run_op(3'd1, 1'b0, 2'd2, 32'hA5A5_F00F, 8'd0, 4'h0, 0, 0, "R3");

    // R10 AP post-delay
    exp_read(1'b1, 2'd3, 3'b001, 32'hCAFE_0001, 1'b0);
    push_bits(64'd0, 5, 1'b0, "R10");
    run_op(3'd0, 1'b1, 2'd3, 32'd0, 8'd5, 4'h0, 1, 32'hCAFE_0001, "R10");
    exp_write(1'b1, 2'd0, 3'b001, 32'h0F0F_1234, "R10");
    run_op(3'd1, 1'b1, 2'd0, 32'h0F0F_1234, 8'd0, 4'h0, 0, 0, "R10");

    // R6 WAIT handling
    exp_read(1'b1, 2'd1, 3'b010, 32'hFFFF_FFFF, 1'b0);
    exp_abort(3'b001);
    exp_read(1'b1, 2'd1, 3'b001, 32'h8000_0003, 1'b0);
    push_bits(64'd0, 2, 1'b0, "R10");
    run_op(3'd0, 1'b1, 2'd1, 32'd0, 8'd2, 4'h0, 1, 32'h8000_0003, "R6");
    exp_write(1'b0, 2'd3, 3'b010, 32'h1357_9BDF, "R6");
    exp_abort(3'b010);
    exp_abort(3'b001);
    exp_write(1'b0, 2'd3, 3'b001, 32'h1357_9BDF, "R6");
    run_op(3'd1, 1'b0, 2'd3, 32'h1357_9BDF, 8'd0, 4'h0, 0, 0, "R6");

    // R5 parity, R8 skip, R9 flush
    exp_read(1'b0, 2'd0, 3'b001, 32'h0000_00F1, 1'b1);
    run_op(3'd0, 1'b0, 2'd0, 32'd0, 8'd0, 4'h8, 1, 32'h8000_0003, "R5");
    run_op(3'd0, 1'b0, 2'd1, 32'd0, 8'd0, 4'h8, 0, 0, "R8");
    run_op(3'd1, 1'b1, 2'd1, 32'h55, 8'd3, 4'h8, 0, 0, "R8");
    push_bits(64'd0, 8, 1'b0, "R9");
    run_op(3'd2, 1'b0, 2'd0, 32'd0, 8'd0, 4'h8, 0, 0, "R9");
    push_bits(64'd0, 8, 1'b0, "R9");
    run_op(3'd2, 1'b0, 2'd0, 32'd0, 8'd0, 4'h0, 0, 0, "R9");

    // R7 FAULT and junk acknowledge
    exp_write(1'b1, 2'd2, 3'b100, 32'hDEAD_BEEF, "R7");
    run_op(3'd1, 1'b1, 2'd2, 32'hDEAD_BEEF, 8'd4, 4'h4, 0, 0, "R7");
    push_bits(64'd0, 8, 1'b0, "R9");
    run_op(3'd2, 1'b0, 2'd0, 32'd0, 8'd0, 4'h4, 0, 0, "R7");
    exp_read(1'b0, 2'd1, 3'b111, 32'h0123_4567, 1'b0);
    run_op(3'd0, 1'b0, 2'd1, 32'd0, 8'd0, 4'h7, 0, 0, "R7");
    push_bits(64'd0, 8, 1'b0, "R9");
    run_op(3'd2, 1'b0, 2'd0, 32'd0, 8'd0, 4'h7, 0, 0, "R7");

    // R11 line sequences
    push_bits({64{1'b1}}, 50, 1'b1, "R11");
    run_op(3'd3, 1'b0, 2'd0, 32'd0, 8'd0, 4'h0, 0, 0, "R11");
    push_bits({64{1'b1}}, 50, 1'b1, "R11");
    push_bits(64'h0000_0000_0000_E79E, 16, 1'b1, "R11");
    push_bits({64{1'b1}}, 50, 1'b1, "R11");
    run_op(3'd4, 1'b0, 2'd0, 32'd0, 8'd0, 4'h0, 0, 0, "R11");
    // R13 reserved code answers without bus activity
    run_op(3'd6, 1'b0, 2'd0, 32'd0, 8'd0, 4'h0, 0, 0, "R13");

    repeat (5) @(negedge clk);
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL R13 watchdog: actual no completion expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule